// File: doc/BRIEF.md
# Per-Lane Output Enable Controller

This block decides, for each of four transmit lanes and four receive lanes, whether the lane's output driver may be on. It combines software disable bits, automatic squelch while the lane's input has lost signal, per-lane and per-direction squelch defeat bits, and a transmit fault lockout. A transmit fault turns its lane off at once and latches it off. The lockout is cleared in one of two ways, and only if the fault is gone at that moment: the host sets and then clears that lane's transmit disable bit, or the module reset input is held low long enough.

Software reaches the control bits through a small register port with a write strobe and a combinational read. The module reset input is active low and is synchronised. Only a low level that lasts at least `RST_MIN_CYC` clock cycles counts as a reset, and it takes effect when the input returns high. Shorter glitches are ignored. A module reset returns every control bit to its default of zero, so squelch is on and no lane is disabled.

Top module: `lane_oe_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, all control bits read 0, no lane is locked, and with no LOS and no fault every `tx_oe` and `rx_oe` bit is 1.
- R2: While transmit disable bit i (register address 0, bit i = lane i) is 1, `tx_oe[i]` is 0.
- R3: While receive disable bit i (address 1) is 1, `rx_oe[i]` is 0.
- R4: While `tx_los[i]` is 1 and transmit squelch defeat bit i (address 2) is 0, `tx_oe[i]` is 0. When that defeat bit is 1, `tx_los[i]` has no effect.
- R5: While `rx_los[i]` is 1 and receive squelch defeat bit i (address 3) is 0, `rx_oe[i]` is 0. When that defeat bit is 1, `rx_los[i]` has no effect.
- R6: `tx_fault[i]` forces `tx_oe[i]` to 0 in the same cycle. From the next edge, `tx_locked[i]` is 1 and the lane stays off after the fault clears.
- R7: If a locked lane's transmit disable bit is written to 1 and later to 0, and the fault is absent when the 0 is seen, the lockout is released. Other lanes keep their own lock state.
- R8: If the fault is present when the disable bit returns to 0, the lane stays locked. A locked lane is never released without a toggle or a module reset.
- R9: A `mod_rst_n` low of at least `RST_MIN_CYC` cycles, followed by a return high, clears all control bits and releases the lockouts on fault-free lanes. A shorter low has no effect.
- R10: A lane whose fault is present during a module reset remains locked after it.
- R11: Reading address a returns the bits last written there (0 = transmit disable, 1 = receive disable, 2 = transmit squelch defeat, 3 = receive squelch defeat).
- R12: Receive outputs do not depend on transmit faults or transmit lockouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| mod_rst_n | input | 1 | Asynchronous active-low module reset request, filtered |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | LANES | Write data, bit i = lane i |
| reg_rdata | output | LANES | Read data of `reg_addr` |
| tx_los | input | LANES | Transmit input loss of signal per lane |
| rx_los | input | LANES | Receive input loss of signal per lane |
| tx_fault | input | LANES | Transmit fault detected per lane |
| tx_oe | output | LANES | Transmit output enable per lane |
| rx_oe | output | LANES | Receive output enable per lane |
| tx_locked | output | LANES | Transmit fault lockout active per lane |

## Verification
On every cycle, the assertions check the following gating rules:
- an enabled output never coincides with its disable bit, an active fault, or an undefeated LOS;
- a fault always leaves the lane locked at the next edge;
- a locked lane never jumps straight back to running;
- a module reset pulse lasts one cycle and leaves every control bit at zero.

Some behaviour only the bench scenarios can show. One case is the full release sequence: a set and then a clear of the disable bit, which must release a fault-free lane and must not release a faulty one. Another is whether the reset filter accepts or rejects pulses of a given length. The last is that every other lane and all register contents are left alone through each of these events.

// File: rtl/lane_oe_pkg.sv
// Shared definitions for the per-lane output enable controller.
// Assumes a fixed 2-bit register address space with one register per field.
package lane_oe_pkg;
    localparam logic [1:0] ADDR_TX_DIS = 2'd0;
    localparam logic [1:0] ADDR_RX_DIS = 2'd1;
    localparam logic [1:0] ADDR_TX_SQD = 2'd2;
    localparam logic [1:0] ADDR_RX_SQD = 2'd3;

    typedef enum logic [1:0] {
        LK_RUN   = 2'd0,
        LK_HELD  = 2'd1,
        LK_ARMED = 2'd2
    } lock_state_e;
endpackage

// File: rtl/lane_oe_rst_filter.sv
// Module reset qualifier: synchronises the active-low request and emits a
// one-cycle pulse on release, but only if the low lasted RST_MIN_CYC cycles.
// Assumes the request is asynchronous to clk.
module lane_oe_rst_filter #(
    parameter int RST_MIN_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic pulse
);
    localparam int CNT_W = $clog2(RST_MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_MIN_CYC);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] low_cnt_q;

    // Synchronise the request, count low cycles, and fire on qualified release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q    <= 2'b11;
            low_cnt_q <= '0;
            pulse     <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], req_n};
            pulse  <= 1'b0;
            if (!sync_q[1]) begin
                if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
            end else begin
                if (low_cnt_q == CNT_MAX) pulse <= 1'b1;
                low_cnt_q <= '0;
            end
        end
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/lane_oe_regs.sv
// Control register file: four per-lane bit vectors, written through a strobe
// and read combinationally. All bits return to zero on system or module reset.
module lane_oe_regs
    import lane_oe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [LANES-1:0] wdata,
    output logic [LANES-1:0] rdata,
    output logic [LANES-1:0] tx_dis,
    output logic [LANES-1:0] rx_dis,
    output logic [LANES-1:0] tx_sqd,
    output logic [LANES-1:0] rx_sqd
);
    // Hold control bits; module reset has priority over a write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tx_dis <= '0;
            rx_dis <= '0;
            tx_sqd <= '0;
            rx_sqd <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_TX_DIS: tx_dis <= wdata;
                ADDR_RX_DIS: rx_dis <= wdata;
                ADDR_TX_SQD: tx_sqd <= wdata;
                default:     rx_sqd <= wdata;
            endcase
        end
    end

    // Select the addressed register for read-back.
    always_comb begin
        case (addr)
            ADDR_TX_DIS: rdata = tx_dis;
            ADDR_RX_DIS: rdata = rx_dis;
            ADDR_TX_SQD: rdata = tx_sqd;
            default:     rdata = rx_sqd;
        endcase
    end

    assert_soft_rst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_dis == '0 && rx_dis == '0 && tx_sqd == '0 && rx_sqd == '0));
endmodule

// File: rtl/lane_oe_lock_fsm.sv
// Transmit fault lockout for one lane. A fault locks the lane. The lockout is
// armed by the disable bit being set and released when it clears with no fault.
// A module reset releases it if no fault is present.
// Assumes fault and disable inputs are synchronous to clk.
module lane_oe_lock_fsm
    import lane_oe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic dis_bit,
    input  logic fault,
    output logic locked
);
    lock_state_e state_q;

    // Advance the lockout state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_RUN;
        end else if (soft_rst) begin
            state_q <= fault ? LK_HELD : LK_RUN;
        end else begin
            case (state_q)
                LK_RUN:   if (fault) state_q <= LK_HELD;
                LK_HELD:  if (dis_bit) state_q <= LK_ARMED;
                LK_ARMED: if (!dis_bit) state_q <= fault ? LK_HELD : LK_RUN;
                default:  state_q <= LK_HELD;
            endcase
        end
    end

    assign locked = (state_q != LK_RUN);

    assert_fault_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> locked);
    assert_no_direct_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_HELD && !soft_rst) |=> locked);
endmodule

// File: rtl/lane_oe_ctrl.sv
// Per-lane output enable controller (top). It combines the soft disable bits,
// LOS squelch with per-direction defeat bits, and the per-lane transmit fault
// lockout into transmit and receive output enables.
// Assumes LOS and fault inputs are synchronous to clk.
module lane_oe_ctrl
    import lane_oe_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int RST_MIN_CYC = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [LANES-1:0] reg_wdata,
    output logic [LANES-1:0] reg_rdata,
    input  logic [LANES-1:0] tx_los,
    input  logic [LANES-1:0] rx_los,
    input  logic [LANES-1:0] tx_fault,
    output logic [LANES-1:0] tx_oe,
    output logic [LANES-1:0] rx_oe,
    output logic [LANES-1:0] tx_locked
);
    logic             soft_rst;
    logic [LANES-1:0] tx_dis, rx_dis, tx_sqd, rx_sqd;

    lane_oe_rst_filter #(.RST_MIN_CYC(RST_MIN_CYC)) rst_filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (mod_rst_n),
        .pulse (soft_rst)
    );

    lane_oe_regs #(.LANES(LANES)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .tx_dis   (tx_dis),
        .rx_dis   (rx_dis),
        .tx_sqd   (tx_sqd),
        .rx_sqd   (rx_sqd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_oe_lock_fsm lock_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .dis_bit  (tx_dis[g]),
            .fault    (tx_fault[g]),
            .locked   (tx_locked[g])
        );
    end

    // Combine per-lane gating terms into output enables.
    always_comb begin
        tx_oe = ~tx_dis & ~tx_locked & ~tx_fault & ~(tx_los & ~tx_sqd);
        rx_oe = ~rx_dis & ~(rx_los & ~rx_sqd);
    end

    assert_tx_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe & (tx_dis | tx_fault | tx_locked)) == '0);
    assert_rx_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_oe & rx_dis) == '0);
    assert_tx_squelch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe & tx_los & ~tx_sqd) == '0);
    assert_rx_squelch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_oe & rx_los & ~rx_sqd) == '0);
endmodule

// File: tb/lane_oe_ctrl_tb.sv
module lane_oe_ctrl_tb_top;
    localparam int L   = 4;
    localparam int MIN = 250;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mod_rst_n = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [L-1:0] reg_wdata = '0;
    logic [L-1:0] reg_rdata;
    logic [L-1:0] tx_los = '0, rx_los = '0, tx_fault = '0;
    logic [L-1:0] tx_oe, rx_oe, tx_locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [L-1:0] m_reg [4];

    always #4 clk = ~clk;

    lane_oe_ctrl #(.LANES(L), .RST_MIN_CYC(MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .mod_rst_n(mod_rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_los(tx_los), .rx_los(rx_los),
        .tx_fault(tx_fault), .tx_oe(tx_oe), .rx_oe(rx_oe), .tx_locked(tx_locked)
    );

    function automatic logic [L-1:0] exp_tx(logic [L-1:0] dis, logic [L-1:0] los,
                                            logic [L-1:0] sqd, logic [L-1:0] lk,
                                            logic [L-1:0] flt);
        return ~dis & ~lk & ~flt & ~(los & ~sqd);
    endfunction

    function automatic logic [L-1:0] exp_rx(logic [L-1:0] dis, logic [L-1:0] los,
                                            logic [L-1:0] sqd);
        return ~dis & ~(los & ~sqd);
    endfunction

    task automatic chk(string req, logic [L-1:0] act, logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [L-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_reg[a] = d;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [L-1:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_mod_rst(int n);
        @(negedge clk);
        mod_rst_n = 1'b0;
        repeat (n) @(negedge clk);
        mod_rst_n = 1'b1;
        idle(8);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 defaults
        chk("R1 tx_oe", tx_oe, '1);
        chk("R1 rx_oe", rx_oe, '1);
        chk("R1 locked", tx_locked, '0);
        for (int a = 0; a < 4; a++) rd_chk("R1 reg", 2'(a), '0);

        // R2..R5, R11, R12: random register and LOS patterns, no faults
        for (int it = 0; it < 300; it++) begin
            logic [1:0] a;
            a = 2'($urandom % 4);
            wr(a, L'($urandom));
            tx_los = L'($urandom);
            rx_los = L'($urandom);
            @(negedge clk);
            chk("R2 R4 tx_oe random", tx_oe,
                exp_tx(m_reg[0], tx_los, m_reg[2], '0, '0));
            chk("R3 R5 R12 rx_oe random", rx_oe,
                exp_rx(m_reg[1], rx_los, m_reg[3]));
            rd_chk("R11 readback", a, m_reg[a]);
        end

        // Corner: all LOS, squelch defeated on every lane
        wr(2'd0, '0); wr(2'd1, '0); wr(2'd2, '1); wr(2'd3, '1);
        tx_los = '1; rx_los = '1;
        idle(1);
        chk("R4 defeat ignores tx_los", tx_oe, '1);
        chk("R5 defeat ignores rx_los", rx_oe, '1);
        wr(2'd2, '0); wr(2'd3, '0);
        idle(1);
        chk("R4 squelch all", tx_oe, '0);
        chk("R5 squelch all", rx_oe, '0);
        tx_los = '0; rx_los = '0;

        // R6 fault on lane 1
        @(negedge clk);
        tx_fault = 4'b0010;
        #1;
        chk("R6 immediate off", tx_oe, 4'b1101);
        @(negedge clk);
        chk("R6 latched", tx_locked, 4'b0010);
        tx_fault = '0;
        idle(3);
        chk("R6 stays off", tx_oe, 4'b1101);
        chk("R12 rx unaffected", rx_oe, '1);

        // R8 toggle while fault present
        tx_fault = 4'b0010;
        wr(2'd0, 4'b0010); idle(1);
        wr(2'd0, 4'b0000); idle(2);
        chk("R8 still locked", tx_locked, 4'b0010);
        tx_fault = '0;
        idle(2);
        chk("R8 still off", tx_oe, 4'b1101);

        // R7 toggle with fault absent
        wr(2'd0, 4'b0010); idle(1);
        wr(2'd0, 4'b0000); idle(2);
        chk("R7 released", tx_locked, '0);
        chk("R7 tx on", tx_oe, '1);

        // R7 lanes independent
        @(negedge clk); tx_fault = 4'b1001;
        @(negedge clk); tx_fault = '0;
        wr(2'd0, 4'b0001); idle(1);
        wr(2'd0, 4'b0000); idle(2);
        chk("R7 only lane0 released", tx_locked, 4'b1000);

        // R9 short pulse ignored
        wr(2'd1, 4'b1111);
        pulse_mod_rst(MIN - 50);
        rd_chk("R9 short ignored reg", 2'd1, 4'b1111);
        chk("R9 short ignored lock", tx_locked, 4'b1000);

        // R9 / R10 long pulse; lane2 has a persistent fault
        @(negedge clk); tx_fault = 4'b0100;
        @(negedge clk);
        pulse_mod_rst(MIN + 50);
        rd_chk("R9 long clears reg", 2'd1, '0);
        chk("R9 R10 lock after reset", tx_locked, 4'b0100);
        tx_fault = '0;
        idle(3);
        chk("R10 still locked", tx_locked, 4'b0100);
        chk("R10 tx_oe", tx_oe, 4'b1011);
        chk("R9 rx_oe", rx_oe, '1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule